// File: doc/BRIEF.md
# Page Buffer Column Pointer

This block keeps the column pointer of a 528-byte page register. The register is seen as three regions: a low half (columns 0 to 255), a high half (256 to 511) and a 16-byte spare region (512 to 527). A decoded region-select command places the pointer at the start of one region. A column byte then sets the start column inside that region. Read strobes and write strobes move the pointer forward one column at a time.

During a sequential read, a read strobe taken at the last column asks for the next page. The block raises a one-cycle next-page pulse, advances its row counter and sets the pointer to the start column for the next page. A high-half selection lasts for one operation only and then falls back to the low half. A spare selection stays in force until a main-half selection is written.

The array, the page transfers and the bus timing belong to the surrounding controller. That controller feeds this block one event at a time and uses the column, the last-column flag and the next-page request.

Top module: `page_col_pointer`

## Requirements
- R1: After reset, the region is low (plane_o = 0), column 0, row 0, next_pg_o low.
- R2: On sel_vld, the sel_code value picks the region. Code 0 sets the low half at column 0. Code 1 sets the high half at column 256. Code 2 sets the spare region at column 512, but only while spare_off is low; with spare_off high, code 2 is ignored. Code 3 is always ignored. plane_o reports the region as 0, 1 or 2.
- R3: On col_vld, the column becomes the region base plus col_byte. In the spare region only col_byte[3:0] is used and bits [7:4] have no effect.
- R4: A read strobe (rd_stb with chip_off low) below the last column advances the column by one.
- R5: The last column is 527 in the spare region. In the low and high halves it is 527 while spare_off is low and 511 while spare_off is high. last_col_o is high exactly when the column is at or beyond the last column.
- R6: A read strobe at the last column, when the row is below its maximum, raises next_pg_o for exactly the following cycle and increments the row. In the spare region the column returns to 512 and the region stays spare. Otherwise the column returns to 0 and the region becomes low.
- R7: On op_done, the high half falls back to the low half. The low half and the spare region stay as they are. The column is not changed.
- R8: wr_stb advances the column by one below the last column and holds it at the last column. It never raises next_pg_o.
- R9: While chip_off is high, rd_stb has no effect.
- R10: row_vld loads row_addr into the row. At the maximum row (8191), a read strobe at the last column leaves the column and the row unchanged and raises no next-page request.
- R11: When events coincide, priority runs in this order: sel_vld (when honoured), col_vld, op_done, read strobe, wr_stb. row_vld acts independently of all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_vld | input | 1 | Region-select command strobe |
| sel_code | input | 2 | Region code: 0 low, 1 high, 2 spare, 3 none |
| col_vld | input | 1 | Column byte strobe |
| col_byte | input | 8 | Start column within the region |
| row_vld | input | 1 | Row load strobe |
| row_addr | input | 13 | Row to load |
| spare_off | input | 1 | High deselects the spare region |
| chip_off | input | 1 | High stops sequential reading |
| rd_stb | input | 1 | Read strobe event |
| wr_stb | input | 1 | Data-load strobe event |
| op_done | input | 1 | Program or erase finished pulse |
| col_o | output | 10 | Current column |
| plane_o | output | 2 | Current region |
| row_o | output | 13 | Current row |
| last_col_o | output | 1 | Column at or beyond the last column |
| next_pg_o | output | 1 | One-cycle next-page request |

## Verification
Sequential reads run from a mid-half start in each region, once with spare_off low and once high. These runs separate the 511 and 527 end columns and show how the spare region and the high half re-enter the next page. Spare selection is tried with a start byte whose upper nibble is set, and again with spare_off high, to show the masked nibble and the refused command. Completion pulses in each region, write-strobe runs into the end column, reads with chip_off high and a read at the top row tell the one-shot fallback, the write saturation, the read gate and the row limit apart. Coincident strobes expose the priority order.

// File: rtl/pgptr_pkg.sv
package pgptr_pkg;

    typedef enum logic [1:0] {
        PL_LOW   = 2'd0,
        PL_HIGH  = 2'd1,
        PL_SPARE = 2'd2
    } plane_e;

endpackage

// File: rtl/pgptr_bounds.sv
module pgptr_bounds
    import pgptr_pkg::*;
#(
    parameter int HALF  = 256,
    parameter int SPARE = 16,
    parameter int COL_W = $clog2(2*HALF+SPARE)
) (
    input  plane_e             plane,
    input  logic               spare_off,
    output logic [COL_W-1:0]   base_col,
    output logic [COL_W-1:0]   last_col
);

    localparam logic [COL_W-1:0] MAIN_END  = COL_W'(2*HALF - 1);
    localparam logic [COL_W-1:0] FULL_END  = COL_W'(2*HALF + SPARE - 1);
    localparam logic [COL_W-1:0] HIGH_BASE = COL_W'(HALF);
    localparam logic [COL_W-1:0] SPR_BASE  = COL_W'(2*HALF);

    always_comb begin
        unique case (plane)
            PL_HIGH:  base_col = HIGH_BASE;
            PL_SPARE: base_col = SPR_BASE;
            default:  base_col = '0;
        endcase
        if (plane == PL_SPARE)
            last_col = FULL_END;
        else
            last_col = spare_off ? MAIN_END : FULL_END;
    end

endmodule

// File: rtl/pgptr_row.sv
module pgptr_row #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] load_val,
    input  logic             inc,
    output logic [ROW_W-1:0] row,
    output logic             at_top
);

    localparam logic [ROW_W-1:0] ROW_MAX = '1;

    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (load)
            row_d = load_val;
        else if (inc && (row_q != ROW_MAX))
            row_d = row_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row    = row_q;
    assign at_top = (row_q == ROW_MAX);

    AST_ROW_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (row_q == ROW_MAX) && !load |=> (row_q == ROW_MAX)); // R10

endmodule

// File: rtl/page_col_pointer.sv
module page_col_pointer
    import pgptr_pkg::*;
#(
    parameter int HALF  = 256,
    parameter int SPARE = 16,
    parameter int ROW_W = 13,
    localparam int COL_W  = $clog2(2*HALF+SPARE),
    localparam int BYTE_W = $clog2(HALF),
    localparam int SP_W   = $clog2(SPARE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_vld,
    input  logic [1:0]        sel_code,
    input  logic              col_vld,
    input  logic [BYTE_W-1:0] col_byte,
    input  logic              row_vld,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic              spare_off,
    input  logic              chip_off,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              op_done,
    output logic [COL_W-1:0]  col_o,
    output logic [1:0]        plane_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              last_col_o,
    output logic              next_pg_o
);

    localparam logic [COL_W-1:0] SPR_BASE  = COL_W'(2*HALF);
    localparam logic [COL_W-1:0] HIGH_BASE = COL_W'(HALF);
    localparam logic [COL_W-1:0] TOP_COL   = COL_W'(2*HALF + SPARE - 1);

    typedef struct packed {
        logic [COL_W-1:0] col;
        plane_e           plane;
        logic             nxt;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    logic [COL_W-1:0] base_col, last_col;
    logic             at_end, row_top, row_inc, sel_ok, rd_ok;

    pgptr_bounds #(.HALF(HALF), .SPARE(SPARE), .COL_W(COL_W)) i_bounds (
        .plane     (st_q.plane),
        .spare_off (spare_off),
        .base_col  (base_col),
        .last_col  (last_col)
    );

    pgptr_row #(.ROW_W(ROW_W)) i_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (row_vld),
        .load_val (row_addr),
        .inc      (row_inc),
        .row      (row_o),
        .at_top   (row_top)
    );

    assign at_end = (st_q.col >= last_col);
    assign sel_ok = sel_vld && ((sel_code == 2'd0) || (sel_code == 2'd1) ||
                                ((sel_code == 2'd2) && !spare_off));
    assign rd_ok  = rd_stb && !chip_off;

    always_comb begin
        st_d     = st_q;
        st_d.nxt = 1'b0;
        row_inc  = 1'b0;
        if (sel_ok) begin
            st_d.plane = plane_e'(sel_code);
            unique case (sel_code)
                2'd1:    st_d.col = HIGH_BASE;
                2'd2:    st_d.col = SPR_BASE;
                default: st_d.col = '0;
            endcase
        end else if (col_vld) begin
            if (st_q.plane == PL_SPARE)
                st_d.col = SPR_BASE + COL_W'(col_byte[SP_W-1:0]);
            else
                st_d.col = base_col + COL_W'(col_byte);
        end else if (op_done) begin
            if (st_q.plane == PL_HIGH)
                st_d.plane = PL_LOW;
        end else if (rd_ok) begin
            if (!at_end) begin
                st_d.col = st_q.col + 1'b1;
            end else if (!row_top) begin
                st_d.nxt = 1'b1;
                row_inc  = 1'b1;
                if (st_q.plane == PL_SPARE) begin
                    st_d.col = SPR_BASE;
                end else begin
                    st_d.col   = '0;
                    st_d.plane = PL_LOW;
                end
            end
        end else if (wr_stb) begin
            if (!at_end)
                st_d.col = st_q.col + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.col   <= '0;
            st_q.plane <= PL_LOW;
            st_q.nxt   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o      = st_q.col;
    assign plane_o    = st_q.plane;
    assign last_col_o = at_end;
    assign next_pg_o  = st_q.nxt;

    AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        col_o <= TOP_COL); // R5
    AST_SPARE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_o == 2'd2) |-> (col_o >= SPR_BASE)); // R3
    AST_NEXT_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        next_pg_o |-> ($past(rd_stb) && !$past(chip_off))); // R6
    AST_NEXT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        next_pg_o |=> !next_pg_o); // R6
    AST_HIGH_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        op_done && (plane_o == 2'd1) && !sel_vld && !col_vld |=> (plane_o == 2'd0)); // R7
    AST_WRITE_NO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && !rd_stb |=> !next_pg_o); // R8
    AST_CHIP_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        chip_off && rd_stb && !sel_vld && !col_vld && !op_done && !wr_stb
        |=> $stable(col_o)); // R9

endmodule

// File: tb/test_page_col_pointer.sv
module test_page_col_pointer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_vld = 0, col_vld = 0, row_vld = 0;
    logic [1:0]  sel_code = 0;
    logic [7:0]  col_byte = 0;
    logic [12:0] row_addr = 0;
    logic        spare_off = 0, chip_off = 0, rd_stb = 0, wr_stb = 0, op_done = 0;
    logic [9:0]  col_o;
    logic [1:0]  plane_o;
    logic [12:0] row_o;
    logic        last_col_o, next_pg_o;

    int compared = 0, mismatched = 0, cycles = 0;
    string cur_req = "R1";
    bit done = 0;

    int m_col = 0, m_plane = 0, m_row = 0, m_nxt = 0;

    always #5 clk = ~clk;

    page_col_pointer i_page_col_pointer (
        .clk(clk), .rst_n(rst_n), .sel_vld(sel_vld), .sel_code(sel_code),
        .col_vld(col_vld), .col_byte(col_byte), .row_vld(row_vld),
        .row_addr(row_addr), .spare_off(spare_off), .chip_off(chip_off),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .op_done(op_done), .col_o(col_o),
        .plane_o(plane_o), .row_o(row_o), .last_col_o(last_col_o),
        .next_pg_o(next_pg_o)
    );

    function automatic int end_col(int plane, bit soff);
        if (plane == 2) return 527;
        return soff ? 511 : 527;
    endfunction

    task automatic chk(string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic model_step();
        int lst = end_col(m_plane, spare_off);
        bit inc = 0;
        m_nxt = 0;
        if (sel_vld && (sel_code < 2 || (sel_code == 2 && !spare_off))) begin
            m_plane = sel_code;
            m_col = sel_code * 256;
        end else if (col_vld) begin
            m_col = (m_plane == 2) ? 512 + (col_byte % 16) : m_plane * 256 + col_byte;
        end else if (op_done) begin
            if (m_plane == 1) m_plane = 0;
        end else if (rd_stb && !chip_off) begin
            if (m_col < lst) m_col++;
            else if (m_row < 8191) begin
                m_nxt = 1;
                inc = 1;
                if (m_plane == 2) m_col = 512;
                else begin m_col = 0; m_plane = 0; end
            end
        end else if (wr_stb) begin
            if (m_col < lst) m_col++;
        end
        if (row_vld) m_row = row_addr;
        else if (inc) m_row++;
    endtask

    task automatic compare_all();
        chk("col_o", col_o, m_col);
        chk("plane_o", plane_o, m_plane);
        chk("row_o", row_o, m_row);
        chk("next_pg_o", next_pg_o, m_nxt);
        chk("last_col_o", last_col_o, m_col >= end_col(m_plane, spare_off));
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        cycles++;
        model_step();
        compare_all();
    endtask

    task automatic clear();
        sel_vld = 0; col_vld = 0; row_vld = 0; rd_stb = 0; wr_stb = 0; op_done = 0;
    endtask

    task automatic sel(int code);
        sel_vld = 1; sel_code = 2'(code); cyc(); clear();
    endtask
    task automatic colb(int b);
        col_vld = 1; col_byte = 8'(b); cyc(); clear();
    endtask
    task automatic reads(int n);
        for (int i = 0; i < n; i++) begin rd_stb = 1; cyc(); end
        clear();
    endtask
    task automatic writes(int n);
        for (int i = 0; i < n; i++) begin wr_stb = 1; cyc(); end
        clear();
    endtask
    task automatic done_pulse();
        op_done = 1; cyc(); clear();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R1";
        compare_all();
        rst_n = 1;
        cyc(); cyc();

        cur_req = "R2"; sel(0); colb(5);
        cur_req = "R4"; reads(3);
        cur_req = "R2"; sel(3);
        cur_req = "R2"; sel(1);
        cur_req = "R3"; colb(250);
        cur_req = "R5"; reads(21);
        cur_req = "R6"; reads(1); cyc(); reads(2);

        spare_off = 1;
        cur_req = "R2"; sel(1); colb(250);
        cur_req = "R5"; reads(5);
        cur_req = "R6"; reads(1); cyc();
        cur_req = "R2"; sel(2);

        spare_off = 0;
        cur_req = "R2"; sel(2);
        cur_req = "R3"; colb(8'hF3);
        cur_req = "R6"; reads(13); cyc(); reads(3);
        cur_req = "R7"; done_pulse();
        spare_off = 1;
        cur_req = "R5"; cyc();
        spare_off = 0;

        cur_req = "R7"; sel(1); colb(40); done_pulse(); done_pulse();
        sel(0); colb(9); done_pulse();

        spare_off = 1;
        cur_req = "R8"; colb(250); writes(10);
        cur_req = "R8"; reads(1); cyc();
        spare_off = 0;
        cur_req = "R8"; sel(2); writes(20);

        cur_req = "R9"; sel(0); colb(100); chip_off = 1; reads(4);
        chip_off = 0; reads(2);

        cur_req = "R10"; row_vld = 1; row_addr = 13'd8191; cyc(); clear();
        sel(1); colb(255); reads(20); reads(3);
        row_vld = 1; row_addr = 13'd17; rd_stb = 1; cyc(); clear();

        cur_req = "R11";
        sel_vld = 1; sel_code = 2'd1; col_vld = 1; col_byte = 8'd7; cyc(); clear();
        col_vld = 1; col_byte = 8'd3; rd_stb = 1; op_done = 1; cyc(); clear();
        op_done = 1; rd_stb = 1; cyc(); clear();
        rd_stb = 1; wr_stb = 1; cyc(); clear();
        sel_vld = 1; sel_code = 2'd3; col_vld = 1; col_byte = 8'd20; cyc(); clear();
        cyc();

        done = 1;
        summary();
    end

endmodule